// File: doc/BRIEF.md
# Shared-Memory Circular Message Queue Agent

This block lets hardware place fixed-size messages into a circular queue in shared memory and take them out again. A software peer can share the same queue, because the block holds no private copy of the queue indices between operations. The region starts at a configurable base address and is divided into `M` equal slots of `SLOT_BYTES` bytes each. The first word of slot 1 stores the tail index and the first word of slot 0 stores the head index. Slots 2 to `M-1` hold messages. Each stored index counts message slots, so the physical slot is the stored value plus two. The queue is empty when head equals tail. It is full when the tail, advanced by one with wrap at `M-2`, equals the head.

A command (enqueue or dequeue) is accepted while the agent is idle. Every operation first reads both indices from memory and then decides. An enqueue pulls one slot's worth of 32-bit words from an input stream and writes them into the tail slot, then publishes the advanced tail. A dequeue reads the head slot, streams its words out, then publishes the advanced head. Each operation ends with a one-cycle response carrying a status. A memory error or a reset abandons the operation before either index is rewritten.

Memory is reached through one 32-bit word port. A transfer completes in the cycle where `mem_valid` and `mem_ready` are both high. Read data and the error flag are valid in that same cycle.

Top module: `shmq_agent`

## Requirements
- R1: While reset is held and in the cycle after it, `cmd_ready` is 1 and `mem_valid`, `rsp_valid`, `out_valid` and `in_ready` are 0.
- R2: Every operation starts with two reads. The first reads the word at `cfg_base` (head). The second reads the word at `cfg_base + SLOT_BYTES` (tail).
- R3: An enqueue on a full queue responds with status FULL (code 1). It makes no memory write and takes no word from the input stream.
- R4: A successful enqueue writes the `SLOT_BYTES/4` input words, in stream order, into message slot `tail+2`. Its last memory access then writes the advanced tail to the tail word, and it responds with status OK (code 0).
- R5: A dequeue on an empty queue responds with status EMPTY (code 2). It makes no memory write and presents no output word.
- R6: A successful dequeue presents the words of slot `head+2`, in address order, on the output stream. After the last word is taken, it writes the advanced head to the head word and responds OK (code 0).
- R7: Index `M-3` advances to 0. With `M-2` message slots, a queue holds at most `M-3` messages.
- R8: A memory error ends the operation with status ERROR (code 3). A reset ends it with no response. In both cases neither index word is written, and the queue contents stay usable.
- R9: Only one operation runs at a time. `cmd_ready` is low while an operation is in progress. No memory access is made while idle, and `rsp_valid` lasts exactly one cycle.
- R10: Each word is little-endian, with byte 0 in bits [7:0] at the lowest byte address. Message word k lies at byte offset 4k within its slot. An index is written zero-extended in bits [IDX_W-1:0] of its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address of slot 0, aligned to SLOT_BYTES |
| cfg_slots | input | IDX_W | Total slot count M (at least 3) |
| cmd_valid | input | 1 | Command request |
| cmd_deq | input | 1 | 1 = dequeue, 0 = enqueue |
| cmd_ready | output | 1 | Agent idle, command accepted when both high |
| in_valid | input | 1 | Enqueue word available |
| in_data | input | 32 | Enqueue word |
| in_ready | output | 1 | Enqueue word taken this cycle |
| out_valid | output | 1 | Dequeue word available |
| out_data | output | 32 | Dequeue word |
| out_ready | input | 1 | Consumer takes the dequeue word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 OK, 1 FULL, 2 EMPTY, 3 ERROR |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Access failed, valid with mem_ready |

## Verification
The bench builds the agent with 64-byte slots (16 words per message) and a six-slot region. This leaves four message slots and a capacity of three messages. With this size, three enqueues reach the full condition, and a fourth operation on the same index pair crosses the wrap from 3 back to 0, all within a few dozen operations. The memory model stalls one cycle in four and the consumer stalls one cycle in eight. This exercises the hold of words on both streams, and errors can be injected on a chosen write address.

// File: rtl/shmq_pkg.sv
// Shared types for the shared-memory queue agent.
// Assumes: status codes are visible at the block's port and must not be renumbered.
package shmq_pkg;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_FULL   = 2'd1,
        ST_EMPTY  = 2'd2,
        ST_MEMERR = 2'd3
    } shmq_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_HEAD,
        S_RD_TAIL,
        S_CHECK,
        S_MOVE,
        S_DRAIN,
        S_WR_IDX
    } shmq_state_e;

    typedef enum logic [1:0] {
        SEL_HEAD,
        SEL_TAIL,
        SEL_MSG
    } shmq_sel_e;

endpackage

// File: rtl/shmq_ring.sv
// Circular index step for a queue of (slots - 2) message entries.
// Assumes: idx is already below slots - 2 and slots is at least 3.
module shmq_ring #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] slots,
    output logic [IDX_W-1:0] nxt
);

    logic [IDX_W-1:0] limit;
    logic [IDX_W-1:0] inc;

    // Advance by one and fold back to zero at the message-slot count.
    always_comb begin
        limit = slots - IDX_W'(2);
        inc   = idx + IDX_W'(1);
        nxt   = (inc == limit) ? '0 : inc;
    end

endmodule

// File: rtl/shmq_addr.sv
// Byte-address generator for the queue region.
// Assumes: base is slot-aligned and SLOT_BYTES is a power of two of at least 64.
module shmq_addr
    import shmq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 16,
    parameter int SLOT_BYTES = 64,
    parameter int CNT_W      = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  shmq_sel_e         sel,
    input  logic [IDX_W-1:0]  msg_idx,
    input  logic [CNT_W-1:0]  word,
    output logic [ADDR_W-1:0] addr
);

    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    logic [ADDR_W-1:0] slot_num;
    logic [ADDR_W-1:0] word_off;

    // Pick the physical slot and the word offset inside it.
    always_comb begin
        case (sel)
            SEL_HEAD: slot_num = '0;
            SEL_TAIL: slot_num = ADDR_W'(1);
            default:  slot_num = ADDR_W'(msg_idx) + ADDR_W'(2);
        endcase
        word_off = (sel == SEL_MSG) ? (ADDR_W'(word) << 2) : '0;
        addr     = base + (slot_num << SLOT_SHIFT) + word_off;
    end

endmodule

// File: rtl/shmq_obuf.sv
// One-word output register with a valid/ready stream.
// Assumes: load is only raised while the register is empty.
module shmq_obuf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Hold a fetched word until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            full_q <= 1'b1;
            data_q <= din;
        end else if (full_q && out_ready) begin
            full_q <= 1'b0;
        end
    end

    assign out_valid = full_q;
    assign out_data  = data_q;

endmodule

// File: rtl/shmq_agent.sv
// Enqueue/dequeue agent for a circular message queue held in shared memory.
// Reads head and tail from memory on each operation, moves one slot of words,
// then publishes the advanced index as its final access.
// Assumes: indices in memory are below cfg_slots - 2; IDX_W is below 32.
module shmq_agent
    import shmq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 16,
    parameter int SLOT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_slots,
    input  logic              cmd_valid,
    input  logic              cmd_deq,
    output logic              cmd_ready,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [31:0]       out_data,
    input  logic              out_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);

    localparam int WORDS = SLOT_BYTES / 4;
    localparam int CNT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS - 1);

    shmq_state_e      state_q;
    logic             op_deq_q;
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rsp_valid_q;
    shmq_status_e     rsp_status_q;

    logic [IDX_W-1:0] head_nxt;
    logic [IDX_W-1:0] tail_nxt;
    logic             q_full;
    logic             q_empty;
    logic             hs;
    logic             obuf_full;
    logic             obuf_load;
    shmq_sel_e        sel;
    logic             unused_rdata_hi;

    shmq_ring #(.IDX_W(IDX_W)) u_head_ring (
        .idx   (head_q),
        .slots (cfg_slots),
        .nxt   (head_nxt)
    );

    shmq_ring #(.IDX_W(IDX_W)) u_tail_ring (
        .idx   (tail_q),
        .slots (cfg_slots),
        .nxt   (tail_nxt)
    );

    shmq_addr #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .SLOT_BYTES (SLOT_BYTES),
        .CNT_W      (CNT_W)
    ) u_addr (
        .base    (cfg_base),
        .sel     (sel),
        .msg_idx (op_deq_q ? head_q : tail_q),
        .word    (cnt_q),
        .addr    (mem_addr)
    );

    shmq_obuf #(.DATA_W(32)) u_obuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (obuf_load),
        .din       (mem_rdata),
        .out_valid (obuf_full),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    assign q_full          = (tail_nxt == head_q);
    assign q_empty         = (head_q == tail_q);
    assign hs              = mem_valid && mem_ready;
    assign obuf_load       = (state_q == S_MOVE) && op_deq_q && hs && !mem_err;
    assign out_valid       = obuf_full;
    assign cmd_ready       = (state_q == S_IDLE);
    assign rsp_valid       = rsp_valid_q;
    assign rsp_status      = rsp_status_q;
    assign unused_rdata_hi = ^mem_rdata[31:IDX_W];

    // Drive the memory request and stream handshakes from the current state.
    always_comb begin
        sel       = SEL_MSG;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        in_ready  = 1'b0;
        case (state_q)
            S_RD_HEAD: begin
                sel       = SEL_HEAD;
                mem_valid = 1'b1;
            end
            S_RD_TAIL: begin
                sel       = SEL_TAIL;
                mem_valid = 1'b1;
            end
            S_MOVE: begin
                sel = SEL_MSG;
                if (op_deq_q) begin
                    mem_valid = !obuf_full;
                end else begin
                    mem_valid = in_valid;
                    mem_we    = 1'b1;
                    mem_wdata = in_data;
                    in_ready  = mem_ready;
                end
            end
            S_WR_IDX: begin
                sel       = op_deq_q ? SEL_HEAD : SEL_TAIL;
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = op_deq_q ? 32'(head_nxt) : 32'(tail_nxt);
            end
            default: begin
                sel = SEL_MSG;
            end
        endcase
    end

    // Sequence one operation: fetch indices, decide, move words, publish index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            op_deq_q     <= 1'b0;
            head_q       <= '0;
            tail_q       <= '0;
            cnt_q        <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= ST_OK;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_deq_q <= cmd_deq;
                        state_q  <= S_RD_HEAD;
                    end
                end
                S_RD_HEAD: begin
                    if (hs) begin
                        if (mem_err) begin
                            rsp_valid_q  <= 1'b1;
                            rsp_status_q <= ST_MEMERR;
                            state_q      <= S_IDLE;
                        end else begin
                            head_q  <= mem_rdata[IDX_W-1:0];
                            state_q <= S_RD_TAIL;
                        end
                    end
                end
                S_RD_TAIL: begin
                    if (hs) begin
                        if (mem_err) begin
                            rsp_valid_q  <= 1'b1;
                            rsp_status_q <= ST_MEMERR;
                            state_q      <= S_IDLE;
                        end else begin
                            tail_q  <= mem_rdata[IDX_W-1:0];
                            state_q <= S_CHECK;
                        end
                    end
                end
                S_CHECK: begin
                    if (op_deq_q && q_empty) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= ST_EMPTY;
                        state_q      <= S_IDLE;
                    end else if (!op_deq_q && q_full) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= ST_FULL;
                        state_q      <= S_IDLE;
                    end else begin
                        cnt_q   <= '0;
                        state_q <= S_MOVE;
                    end
                end
                S_MOVE: begin
                    if (hs) begin
                        if (mem_err) begin
                            rsp_valid_q  <= 1'b1;
                            rsp_status_q <= ST_MEMERR;
                            state_q      <= S_IDLE;
                        end else if (cnt_q == LAST_WORD) begin
                            state_q <= op_deq_q ? S_DRAIN : S_WR_IDX;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                S_DRAIN: begin
                    if (!obuf_full) begin
                        state_q <= S_WR_IDX;
                    end
                end
                S_WR_IDX: begin
                    if (hs) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= mem_err ? ST_MEMERR : ST_OK;
                        state_q      <= S_IDLE;
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/shmq_agent_chk.sv
// Protocol checker for shmq_agent, attached with bind below.
// Assumes: observes only the agent's ports.
module shmq_agent_chk #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 16,
    parameter int SLOT_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              in_ready,
    input logic              out_valid,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              mem_err
);

    logic wr_seen;
    logic idx_addr;

    assign idx_addr = (mem_addr == cfg_base) ||
                      (mem_addr == cfg_base + ADDR_W'(SLOT_BYTES));

    // Remember whether the current operation has attempted any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            wr_seen <= 1'b0;
        end else if (mem_valid && mem_ready && mem_we) begin
            wr_seen <= 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !mem_valid && !rsp_valid && !out_valid && !in_ready));

    p_idle_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_valid);

    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_refusal_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == 2'd1 || rsp_status == 2'd2)) |-> !wr_seen);

    p_err_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_err) |=> (rsp_valid && rsp_status == 2'd3));

    p_index_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> $past(mem_valid && mem_ready && mem_we && idx_addr));

    p_index_zero_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && idx_addr) |-> (mem_wdata[31:IDX_W] == '0));

endmodule

bind shmq_agent shmq_agent_chk #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .SLOT_BYTES (SLOT_BYTES)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_base   (cfg_base),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err)
);

// File: tb/test_shmq_agent.sv
// Scoreboard bench for shmq_agent with a stalling word-memory model.
module test_shmq_agent;

    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 16;
    localparam int SLOT_BYTES = 64;
    localparam int WORDS      = SLOT_BYTES / 4;
    localparam int M          = 6;
    localparam int MW         = M * WORDS;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam logic [1:0] OK = 2'd0, FULL = 2'd1, EMPTY = 2'd2, MERR = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0, cmd_deq = 1'b0, cmd_ready;
    logic              in_valid = 1'b0, in_ready;
    logic [31:0]       in_data = '0;
    logic              out_valid, out_ready;
    logic [31:0]       out_data;
    logic              rsp_valid;
    logic [1:0]        rsp_status;
    logic              mem_valid, mem_we, mem_ready, mem_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;

    logic [31:0] mem [0:MW-1];
    logic [31:0] log_addr [0:1023];
    logic        log_we [0:1023];
    int          log_n = 0;
    logic [7:0]  stall = '0;
    logic        clr_mem = 1'b1;
    logic        err_en = 1'b0, err_we = 1'b0;
    logic [31:0] err_addr = '0;
    int          widx;

    int n_checks = 0, n_err = 0;
    logic [31:0] exp_data [$];
    logic [1:0]  exp_rsp [$];
    string       exp_tag [$];

    always #5 clk = ~clk;

    shmq_agent #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_BYTES(SLOT_BYTES)) i_shmq_agent (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_slots(IDX_W'(M)),
        .cmd_valid(cmd_valid), .cmd_deq(cmd_deq), .cmd_ready(cmd_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err)
    );

    assign widx      = int'((mem_addr - BASE) >> 2);
    assign mem_ready = (stall[1:0] != 2'b11);
    assign out_ready = (stall[2:0] != 3'd5);
    assign mem_rdata = (widx >= 0 && widx < MW) ? mem[widx] : 32'hDEAD_BEEF;
    assign mem_err   = err_en && mem_valid && (mem_addr == err_addr) && (mem_we == err_we);

    // Memory model: stall pattern, writes and access log.
    always @(posedge clk) begin
        stall <= stall + 8'd1;
        if (clr_mem) begin
            for (int i = 0; i < MW; i++) mem[i] <= '0;
        end else if (mem_valid && mem_ready) begin
            if (mem_we && !mem_err && widx >= 0 && widx < MW) mem[widx] <= mem_wdata;
            if (log_n < 1024) begin
                log_addr[log_n] <= mem_addr;
                log_we[log_n]   <= mem_we;
                log_n           <= log_n + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int writes_since(int s);
        int c = 0;
        for (int i = s; i < log_n; i++) if (log_we[i]) c++;
        return c;
    endfunction

    function automatic int idx_writes_since(int s);
        int c = 0;
        for (int i = s; i < log_n; i++)
            if (log_we[i] && (log_addr[i] == BASE || log_addr[i] == BASE + SLOT_BYTES)) c++;
        return c;
    endfunction

    // Monitor: pops expected words and responses as the design produces them.
    initial begin
        logic prev_rsp = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid && out_ready) begin
                    if (exp_data.size() == 0) begin
                        n_checks++; n_err++;
                        $display("FAIL R5/R6 unexpected output word: actual=%h expected=none", out_data);
                    end else begin
                        check("R6 dequeue word order", out_data, exp_data.pop_front());
                    end
                end
                if (rsp_valid) begin
                    if (exp_rsp.size() == 0) begin
                        n_checks++; n_err++;
                        $display("FAIL R9 unexpected response: actual=%0d expected=none", rsp_status);
                    end else begin
                        check(exp_tag.pop_front(), 32'(rsp_status), 32'(exp_rsp.pop_front()));
                    end
                end
                if (rsp_valid && prev_rsp) begin
                    n_checks++; n_err++;
                    $display("FAIL R9 response longer than one cycle: actual=2 expected=1");
                end
                prev_rsp = rsp_valid;
            end else begin
                prev_rsp = 1'b0;
            end
        end
    end

    // Driver: issues one command, streams enqueue words, waits for the response.
    task automatic do_op(bit deq, logic [1:0] st, string tag, logic [31:0] seed, output int start);
        bit got = 0;
        start = log_n;
        if (deq && (st == OK || st == MERR))
            for (int k = 0; k < WORDS; k++) exp_data.push_back(seed + 32'(k));
        exp_rsp.push_back(st);
        exp_tag.push_back(tag);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_deq = deq;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R9 busy blocks commands", 32'(cmd_ready), 32'd0);
        if (!deq) begin
            for (int k = 0; k < WORDS && !got; k++) begin
                in_valid = 1'b1; in_data = seed + 32'(k);
                do begin
                    @(negedge clk);
                    if (rsp_valid) got = 1;
                end while (!in_ready && !got);
                if (!got) begin @(posedge clk); #1; end
            end
            in_valid = 1'b0;
        end
        while (!got) begin
            @(negedge clk);
            if (rsp_valid) got = 1;
        end
        repeat (2) @(negedge clk);
        check({tag, " stream drained"}, 32'(exp_data.size()), 32'd0);
    endtask

    task automatic check_slot(string req, int slot, logic [31:0] seed);
        for (int k = 0; k < WORDS; k++) check(req, mem[slot * WORDS + k], seed + 32'(k));
    endtask

    task automatic check_reset_outputs();
        check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        check("R1 mem_valid", 32'(mem_valid), 32'd0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        @(posedge clk); #1;
        clr_mem = 1'b0; rst_n = 1'b1;

        // R2, R4, R10: first enqueue into an empty queue lands in slot 2.
        do_op(0, OK, "R4 enqueue A", 32'hA000_0000, s);
        check("R2 first access reads head", log_addr[s], BASE);
        check("R2 first access is read", 32'(log_we[s]), 32'd0);
        check("R2 second access reads tail", log_addr[s+1], BASE + SLOT_BYTES);
        check("R2 second access is read", 32'(log_we[s+1]), 32'd0);
        check("R4 last access is tail write", log_addr[log_n-1], BASE + SLOT_BYTES);
        check("R10 tail word zero-extended", mem[WORDS], 32'd1);
        check_slot("R4 R10 slot 2 words", 2, 32'hA000_0000);

        do_op(0, OK, "R4 enqueue B", 32'hB000_0000, s);
        do_op(0, OK, "R4 enqueue C", 32'hC000_0000, s);
        check("R7 tail after three", mem[WORDS], 32'd3);
        check_slot("R4 slot 4 words", 4, 32'hC000_0000);

        // R3: fourth message does not fit.
        do_op(0, FULL, "R3 enqueue on full", 32'hD000_0000, s);
        check("R3 no write when full", 32'(writes_since(s)), 32'd0);
        check("R3 tail unchanged", mem[WORDS], 32'd3);

        // R6: drain in order.
        do_op(1, OK, "R6 dequeue A", 32'hA000_0000, s);
        check("R6 head advanced", mem[0], 32'd1);
        check("R6 last access is head write", log_addr[log_n-1], BASE);
        do_op(1, OK, "R6 dequeue B", 32'hB000_0000, s);
        do_op(1, OK, "R6 dequeue C", 32'hC000_0000, s);
        check("R6 head after three", mem[0], 32'd3);

        // R5: empty queue.
        do_op(1, EMPTY, "R5 dequeue on empty", 32'h0, s);
        check("R5 no write when empty", 32'(writes_since(s)), 32'd0);

        // R7: wrap of both indices.
        do_op(0, OK, "R7 enqueue E at last slot", 32'hE000_0000, s);
        check_slot("R7 slot 5 words", 5, 32'hE000_0000);
        check("R7 tail wraps to 0", mem[WORDS], 32'd0);
        do_op(1, OK, "R7 dequeue E", 32'hE000_0000, s);
        check("R7 head wraps to 0", mem[0], 32'd0);

        // R8: error on an enqueue message write.
        err_en = 1'b1; err_we = 1'b1; err_addr = BASE + 2 * SLOT_BYTES + 5 * 4;
        do_op(0, MERR, "R8 enqueue memory error", 32'h5000_0000, s);
        err_en = 1'b0;
        check("R8 no index write after error", 32'(idx_writes_since(s)), 32'd0);
        check("R8 tail kept", mem[WORDS], 32'd0);

        // R8: error on the head write of a dequeue.
        do_op(0, OK, "R4 enqueue F", 32'hF000_0000, s);
        err_en = 1'b1; err_we = 1'b1; err_addr = BASE;
        do_op(1, MERR, "R8 dequeue memory error", 32'hF000_0000, s);
        err_en = 1'b0;
        check("R8 head kept", mem[0], 32'd0);
        do_op(1, OK, "R8 dequeue F after error", 32'hF000_0000, s);
        check("R8 head advanced on retry", mem[0], 32'd1);

        // R8: reset in the middle of an enqueue.
        do_op(0, OK, "R4 enqueue G", 32'h6000_0000, s);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_deq = 1'b0;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1; in_data = 32'h7000_0000 + 32'(k);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_outputs();
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R8 tail kept across reset", mem[WORDS], 32'd2);
        do_op(1, OK, "R8 dequeue G after reset", 32'h6000_0000, s);
        check("R8 head after reset recovery", mem[0], 32'd2);

        repeat (4) @(negedge clk);
        check("R6 no leftover expected words", 32'(exp_data.size()), 32'd0);
        check("R9 no leftover responses", 32'(exp_rsp.size()), 32'd0);
        summary();
        $finish;
    end

endmodule